// File: doc/BRIEF.md
# Nonvolatile Array Write Pacer with Clock Stretching

This block sits behind an SMBus slave bit engine. It accepts the data bytes of write-byte and block-write transactions aimed at a nonvolatile byte array, and it issues them to the array no faster than the array can program them. One byte takes PROG_CYC system clock cycles to program, which is about 250 µs in real time. A single holding register lets one byte arrive during a programming cycle. Any byte that arrives while that register is in use is held back by asserting the clock-stretch request to the bit engine. The engine keeps SCL low until the request drops.

A transaction is opened with a block-begin event that carries the start address and the byte count N. The start address needs no alignment. The block is accepted only if it fits entirely below the top of the array (0xFBFF) and every 256-byte page it touches is already marked erased. The erase flags live in the block. They are cleared by reset and are set one page at a time by a mark input. Bytes that cannot be programmed are dropped and raise a sticky error flag. A stop event closes the block. A byte that is already held is still programmed, after which the block goes idle.

Top module: `nvm_write_pacer`

## Requirements
- R1: After reset, scl_hold, prog_we, busy and err_flag are all 0, and every page is marked not erased.
- R2: An accepted byte that arrives while no programming is in progress produces a one-cycle prog_we pulse on the following cycle, with prog_data equal to the received byte.
- R3: Within a block, the k-th received byte (counting from 0) targets address start+k, so the address advances by one for each byte.
- R4: Each prog_we starts a programming cycle during which busy is high for exactly PROG_CYC cycles. Two prog_we pulses are never closer than PROG_CYC cycles.
- R5: A byte that arrives while programming is in progress is held, and scl_hold goes high on the next cycle. scl_hold stays high until the cycle in which the held byte's prog_we appears, and it is low in that cycle.
- R6: A block may start at any address and may cross page boundaries. Its bytes are programmed when all the pages it touches are erased.
- R7: A block is rejected if start+N-1 exceeds 0xFBFF or N is 0. A rejected block programs none of its bytes and sets err_flag. A block that ends exactly at 0xFBFF is accepted.
- R8: A block is rejected if any page it touches, where the page index is address bits [15:8], is not marked erased. A rejected block programs none of its bytes, including bytes in erased pages, and sets err_flag.
- R9: Bytes received beyond the N announced at block begin are not programmed, and they set err_flag.
- R10: err_flag is sticky until err_clr. When an error event and err_clr fall in the same cycle, err_flag ends up set.
- R11: After stop_evt, received bytes are not programmed and they set err_flag. Once the last programming cycle ends, busy and scl_hold are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| blk_begin | input | 1 | One-cycle pulse opening a block |
| blk_addr | input | ADDR_W | Start address of the block |
| blk_len | input | LEN_W | Number of bytes N announced for the block |
| byte_valid | input | 1 | One-cycle pulse: a data byte was received |
| byte_data | input | DATA_W | Received data byte |
| stop_evt | input | 1 | One-cycle pulse: stop condition seen |
| erase_mark | input | 1 | Mark the page in erase_page as erased |
| erase_page | input | ADDR_W-PAGE_W | Page index to mark |
| err_clr | input | 1 | Clear the sticky error flag |
| scl_hold | output | 1 | Request to the bit engine to hold SCL low |
| prog_we | output | 1 | One-cycle program strobe to the array |
| prog_addr | output | ADDR_W | Array address being programmed |
| prog_data | output | DATA_W | Byte being programmed |
| busy | output | 1 | Programming in progress or a byte is held |
| err_flag | output | 1 | Sticky error flag |

## Verification
The assertions take for granted that the bit engine sends no new byte while scl_hold is high, and that blk_begin, byte_valid and stop_evt never share a cycle. The bench keeps to both rules. Each byte is a single-cycle pulse, the bench waits out scl_hold before the next one, and the begin, data and stop events are placed in separate cycles with random gaps. Random blocks cover start addresses near page boundaries, near and above the top of the array, and anywhere in the address space. Their lengths range from 1 to 6, and some blocks receive one byte too many or one too few. The page erase pattern is fixed and random within the random phase.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  typedef enum logic [1:0] {
    BV_NONE,
    BV_ISSUE,
    BV_PARK,
    BV_DROP
  } byte_verdict_e;
endpackage

// File: rtl/nvp_prog_timer.sv
module nvp_prog_timer #(
  parameter int PROG_CYC = 12500,
  localparam int CYC_W = $clog2(PROG_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic free,
  output logic last
);
  logic [CYC_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (start)               cnt_d = CYC_W'(PROG_CYC);
    else if (cnt_q != '0)    cnt_d = cnt_q - CYC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CYC_W'(1));
  assign free = (cnt_q <= CYC_W'(1));

  // R4: a new programming cycle is never started in the middle of one
  p_start_when_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cnt_q <= CYC_W'(1)));
endmodule

// File: rtl/nvp_range_check.sv
module nvp_range_check #(
  parameter int ADDR_W   = 16,
  parameter int LEN_W    = 8,
  parameter int PAGE_W   = 8,
  parameter int TOP_ADDR = 'hFBFF,
  localparam int PG_IDX_W = ADDR_W - PAGE_W
) (
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [LEN_W-1:0]    len,
  output logic                in_range,
  output logic [PG_IDX_W-1:0] first_page,
  output logic [PG_IDX_W-1:0] last_page
);
  logic [ADDR_W:0] end_addr;

  always_comb begin
    end_addr   = {1'b0, start_addr} + (ADDR_W+1)'(len) - (ADDR_W+1)'(1);
    in_range   = (len != '0) && (end_addr <= (ADDR_W+1)'(TOP_ADDR));
    first_page = start_addr[ADDR_W-1:PAGE_W];
    last_page  = end_addr[ADDR_W-1:PAGE_W];
  end
endmodule

// File: rtl/nvp_erase_map.sv
module nvp_erase_map #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int NPAGES = 252,
  localparam int PG_IDX_W = ADDR_W - PAGE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mark,
  input  logic [PG_IDX_W-1:0] mark_page,
  input  logic [PG_IDX_W-1:0] span_lo,
  input  logic [PG_IDX_W-1:0] span_hi,
  output logic                span_erased,
  input  logic [ADDR_W:0]     byte_addr,
  output logic                byte_erased
);
  logic [NPAGES-1:0]  flags_q, flags_d;
  logic               mark_ok;
  logic [PG_IDX_W:0]  byte_idx;

  assign mark_ok = mark && ({1'b0, mark_page} < (PG_IDX_W+1)'(NPAGES));

  always_comb begin
    flags_d = flags_q;
    if (mark_ok) flags_d[mark_page] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (mark_ok) flags_q <= flags_d;
  end

  always_comb begin
    span_erased = 1'b1;
    for (int p = 0; p < NPAGES; p++) begin
      if ((PG_IDX_W'(p) >= span_lo) && (PG_IDX_W'(p) <= span_hi) && !flags_q[p])
        span_erased = 1'b0;
    end
  end

  always_comb begin
    byte_idx    = byte_addr[ADDR_W:PAGE_W];
    byte_erased = 1'b0;
    if (byte_idx < (PG_IDX_W+1)'(NPAGES))
      byte_erased = flags_q[byte_idx[PG_IDX_W-1:0]];
  end

  // R8: a marked page reads back as erased on the next cycle
  p_mark_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mark_ok |=> flags_q[$past(mark_page)]);
endmodule

// File: rtl/nvm_write_pacer.sv
module nvm_write_pacer
  import nvp_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 8,
  parameter int PAGE_W   = 8,
  parameter int TOP_ADDR = 'hFBFF,
  parameter int PROG_CYC = 12500,
  localparam int PG_IDX_W = ADDR_W - PAGE_W,
  localparam int NPAGES   = (TOP_ADDR + 1) >> PAGE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blk_begin,
  input  logic [ADDR_W-1:0]   blk_addr,
  input  logic [LEN_W-1:0]    blk_len,
  input  logic                byte_valid,
  input  logic [DATA_W-1:0]   byte_data,
  input  logic                stop_evt,
  input  logic                erase_mark,
  input  logic [PG_IDX_W-1:0] erase_page,
  input  logic                err_clr,
  output logic                scl_hold,
  output logic                prog_we,
  output logic [ADDR_W-1:0]   prog_addr,
  output logic [DATA_W-1:0]   prog_data,
  output logic                busy,
  output logic                err_flag
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // block range and erase checks
  logic                in_range, span_erased, byte_erased, blk_legal;
  logic [PG_IDX_W-1:0] first_page, last_page;
  logic [ADDR_W:0]     cur_addr_q, cur_addr_d;

  nvp_range_check #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W), .TOP_ADDR(TOP_ADDR)
  ) u_range (
    .start_addr(blk_addr), .len(blk_len), .in_range(in_range),
    .first_page(first_page), .last_page(last_page)
  );

  nvp_erase_map #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NPAGES(NPAGES)
  ) u_emap (
    .clk(clk), .rst_n(rst_int_n), .mark(erase_mark), .mark_page(erase_page),
    .span_lo(first_page), .span_hi(last_page), .span_erased(span_erased),
    .byte_addr(cur_addr_q), .byte_erased(byte_erased)
  );

  assign blk_legal = in_range && span_erased;

  // programming timer
  logic t_start, t_busy, t_free, t_last;

  nvp_prog_timer #(.PROG_CYC(PROG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .start(t_start),
    .busy(t_busy), .free(t_free), .last(t_last)
  );

  // control state
  logic              active_q, active_d;
  logic              blk_ok_q, blk_ok_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic [DATA_W-1:0] pend_data_q, pend_data_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] we_addr_q, we_addr_d;
  logic [DATA_W-1:0] we_data_q, we_data_d;
  logic              err_q, err_d;
  logic              byte_ok, issue_pend, err_set;
  logic              ctl_en, we_load, pend_en;
  byte_verdict_e     verdict;

  always_comb begin
    byte_ok = active_q && blk_ok_q && (remain_q != '0) &&
              (cur_addr_q <= (ADDR_W+1)'(TOP_ADDR)) && byte_erased;

    if (!byte_valid)               verdict = BV_NONE;
    else if (!byte_ok)             verdict = BV_DROP;
    else if (t_free && !pend_q)    verdict = BV_ISSUE;
    else                           verdict = BV_PARK;

    issue_pend = pend_q && t_last;
    t_start    = (verdict == BV_ISSUE) || issue_pend;
    err_set    = (verdict == BV_DROP) || (blk_begin && !blk_legal);
  end

  // next state
  always_comb begin
    active_d   = active_q;
    blk_ok_d   = blk_ok_q;
    cur_addr_d = cur_addr_q;
    remain_d   = remain_q;
    if (blk_begin) begin
      active_d   = 1'b1;
      blk_ok_d   = blk_legal;
      cur_addr_d = {1'b0, blk_addr};
      remain_d   = blk_len;
    end else if (stop_evt) begin
      active_d = 1'b0;
      remain_d = '0;
    end else if (byte_valid && active_q) begin
      cur_addr_d = cur_addr_q + (ADDR_W+1)'(1);
      if (remain_q != '0) remain_d = remain_q - LEN_W'(1);
    end
    ctl_en = blk_begin || stop_evt || byte_valid;

    pend_d      = pend_q;
    pend_addr_d = pend_addr_q;
    pend_data_d = pend_data_q;
    if (verdict == BV_PARK) begin
      pend_d      = 1'b1;
      pend_addr_d = cur_addr_q[ADDR_W-1:0];
      pend_data_d = byte_data;
    end else if (issue_pend) begin
      pend_d = 1'b0;
    end
    pend_en = (verdict == BV_PARK) || issue_pend;

    we_d      = t_start;
    we_addr_d = issue_pend ? pend_addr_q : cur_addr_q[ADDR_W-1:0];
    we_data_d = issue_pend ? pend_data_q : byte_data;
    we_load   = t_start;

    if (err_set)      err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    else              err_d = err_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      active_q   <= 1'b0;
      blk_ok_q   <= 1'b0;
      cur_addr_q <= '0;
      remain_q   <= '0;
    end else if (ctl_en) begin
      active_q   <= active_d;
      blk_ok_q   <= blk_ok_d;
      cur_addr_q <= cur_addr_d;
      remain_q   <= remain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (pend_en) begin
      pend_q      <= pend_d;
      pend_addr_q <= pend_addr_d;
      pend_data_q <= pend_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      we_q      <= 1'b0;
      we_addr_q <= '0;
      we_data_q <= '0;
      err_q     <= 1'b0;
    end else begin
      we_q  <= we_d;
      err_q <= err_d;
      if (we_load) begin
        we_addr_q <= we_addr_d;
        we_data_q <= we_data_d;
      end
    end
  end

  assign scl_hold  = pend_q;
  assign prog_we   = we_q;
  assign prog_addr = we_addr_q;
  assign prog_data = we_data_q;
  assign busy      = t_busy || pend_q;
  assign err_flag  = err_q;

  // R2: the program strobe lasts one cycle
  p_we_single_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    prog_we |=> !prog_we);

  // R3: each byte inside an open block advances the address by one
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (byte_valid && active_q && !blk_begin && !stop_evt) |=>
      (cur_addr_q == $past(cur_addr_q) + (ADDR_W+1)'(1)));

  // R5: stretching only while the array is programming
  p_hold_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    scl_hold |-> t_busy);

  // R5: release of the stretch coincides with programming the held byte
  p_hold_release_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(scl_hold) |-> prog_we);

  // R7: nothing above the top of the array is ever programmed
  p_top_limit_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    prog_we |-> ({1'b0, prog_addr} <= (ADDR_W+1)'(TOP_ADDR)));

  // R10: the error flag stays set until cleared
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (err_flag && !err_clr) |=> err_flag);
endmodule

// File: tb/nvm_write_pacer_bench.sv
module nvm_write_pacer_bench;
  localparam int PROG_CYC = 12;
  localparam int TOP      = 'hFBFF;
  localparam int NPG      = 252;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        blk_begin, byte_valid, stop_evt, erase_mark, err_clr;
  logic [15:0] blk_addr;
  logic [7:0]  blk_len, byte_data, erase_page;
  logic        scl_hold, prog_we, busy, err_flag;
  logic [15:0] prog_addr;
  logic [7:0]  prog_data;

  always #10 clk = ~clk;

  nvm_write_pacer #(.PROG_CYC(PROG_CYC)) u_nvm_write_pacer (
    .clk(clk), .rst_n(rst_n), .blk_begin(blk_begin), .blk_addr(blk_addr),
    .blk_len(blk_len), .byte_valid(byte_valid), .byte_data(byte_data),
    .stop_evt(stop_evt), .erase_mark(erase_mark), .erase_page(erase_page),
    .err_clr(err_clr), .scl_hold(scl_hold), .prog_we(prog_we),
    .prog_addr(prog_addr), .prog_data(prog_data), .busy(busy),
    .err_flag(err_flag)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit erased [NPG];

  int obs_n = 0;
  int obs_addr [64];
  int obs_data [64];
  int obs_cyc  [64];
  int last_we_cyc = -1000;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n && prog_we) begin
      checks++;
      if (cyc - last_we_cyc < PROG_CYC) begin
        errors++;
        $display("FAIL R4 strobe gap actual=%0d expected>=%0d", cyc - last_we_cyc, PROG_CYC);
      end
      last_we_cyc = cyc;
      if (obs_n < 64) begin
        obs_addr[obs_n] = int'(prog_addr);
        obs_data[obs_n] = int'(prog_data);
        obs_cyc[obs_n]  = cyc;
      end
      obs_n++;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_begin(input int a, input int n, input bit clr = 1'b0);
    blk_begin = 1'b1; blk_addr = 16'(a); blk_len = 8'(n); err_clr = clr;
    tick();
    blk_begin = 1'b0; err_clr = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    byte_valid = 1'b1; byte_data = d;
    tick();
    byte_valid = 1'b0;
    while (scl_hold) tick();
    tick($urandom_range(0, 3));
  endtask

  task automatic do_stop();
    stop_evt = 1'b1; tick(); stop_evt = 1'b0;
  endtask

  task automatic do_erase(input int p);
    erase_mark = 1'b1; erase_page = 8'(p); tick(); erase_mark = 1'b0;
    erased[p] = 1'b1;
  endtask

  task automatic do_clr();
    err_clr = 1'b1; tick(); err_clr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) tick();
    tick();
  endtask

  function automatic bit model_ok(input int a, input int n);
    if (n == 0 || a + n - 1 > TOP) return 1'b0;
    for (int p = a >> 8; p <= (a + n - 1) >> 8; p++)
      if (!erased[p]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run_txn(input int a, input int n, input int nsend, input string tag);
    int          exp_n;
    bit          ok;
    bit          exp_err;
    logic [7:0]  d [8];
    ok      = model_ok(a, n);
    exp_err = !ok || (nsend > n);
    exp_n   = ok ? ((nsend < n) ? nsend : n) : 0;
    for (int k = 0; k < 8; k++) d[k] = 8'($urandom);
    obs_n = 0;
    do_begin(a, n);
    tick($urandom_range(0, 2));
    for (int k = 0; k < nsend; k++) send_byte(d[k]);
    do_stop();
    wait_idle();
    chk(obs_n == exp_n, {tag, " write count"}, obs_n, exp_n);
    for (int k = 0; k < exp_n && k < obs_n; k++) begin
      chk(obs_addr[k] == a + k, "R3 address", obs_addr[k], a + k);
      chk(obs_data[k] == int'(d[k]), "R2 data", obs_data[k], int'(d[k]));
    end
    chk(err_flag == exp_err, {tag, " error flag"}, int'(err_flag), int'(exp_err));
    chk(!scl_hold && !busy, "R11 idle after stop", int'({scl_hold, busy}), 0);
    do_clr();
    chk(!err_flag, "R10 clear", int'(err_flag), 0);
  endtask

  initial begin
    int a, n, ns, cnt;
    bit holdbad;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    blk_begin = 0; byte_valid = 0; stop_evt = 0; erase_mark = 0; err_clr = 0;
    blk_addr = 0; blk_len = 0; byte_data = 0; erase_page = 0;
    for (int p = 0; p < NPG; p++) erased[p] = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk(!scl_hold && !prog_we && !busy && !err_flag, "R1 reset outputs",
        int'({scl_hold, prog_we, busy, err_flag}), 0);

    // R8 nothing erased yet
    run_txn('h0100, 2, 2, "R8");

    do_erase(1);
    do_erase(2);
    // R2 single byte write
    run_txn('h0105, 1, 1, "R2");
    // R6 unaligned start crossing a page boundary
    run_txn('h01FE, 4, 4, "R6");
    // R8 touches page 3, which is not erased
    run_txn('h02FE, 4, 4, "R8");

    do_erase(251);
    // R7 block ending exactly at the top is accepted, one past is rejected
    run_txn('hFBFC, 4, 4, "R7");
    run_txn('hFBFD, 4, 4, "R7");
    run_txn('h0180, 0, 0, "R7");
    // R9 one byte more than announced
    run_txn('h0110, 2, 3, "R9");

    // R4 busy lasts PROG_CYC cycles after a strobe
    obs_n = 0;
    do_begin('h0140, 1);
    byte_valid = 1'b1; byte_data = 8'h5A; tick(); byte_valid = 1'b0;
    chk(prog_we == 1'b1, "R2 strobe next cycle", int'(prog_we), 1);
    cnt = 0;
    while (busy && cnt < 100) begin cnt++; tick(); end
    chk(cnt == PROG_CYC, "R4 busy length", cnt, PROG_CYC);
    do_stop();
    tick();

    // R5 stretch while a byte is held
    obs_n = 0;
    do_begin('h0120, 2);
    byte_valid = 1'b1; byte_data = 8'hA1; tick(); byte_valid = 1'b0;
    tick();
    byte_valid = 1'b1; byte_data = 8'hB2; tick(); byte_valid = 1'b0;
    chk(scl_hold == 1'b1, "R5 hold asserted", int'(scl_hold), 1);
    holdbad = 1'b0;
    cnt = 0;
    while (!prog_we && cnt < 100) begin
      if (!scl_hold) holdbad = 1'b1;
      cnt++;
      tick();
    end
    chk(!holdbad, "R5 hold kept until issue", int'(holdbad), 0);
    chk(scl_hold == 1'b0, "R5 hold released with strobe", int'(scl_hold), 0);
    do_stop();
    wait_idle();
    chk(obs_n == 2, "R5 write count", obs_n, 2);
    chk(obs_cyc[1] - obs_cyc[0] == PROG_CYC, "R4 back-to-back spacing",
        obs_cyc[1] - obs_cyc[0], PROG_CYC);
    chk(obs_addr[1] == 'h121 && obs_data[1] == 'hB2, "R3 held byte target",
        obs_addr[1], 'h121);

    // R11 bytes after stop are dropped
    obs_n = 0;
    do_begin('h0130, 4);
    send_byte(8'h11);
    do_stop();
    send_byte(8'h22);
    wait_idle();
    chk(obs_n == 1, "R11 write count", obs_n, 1);
    chk(err_flag == 1'b1, "R11 error after stop", int'(err_flag), 1);
    chk(!scl_hold && !busy, "R11 idle", int'({scl_hold, busy}), 0);
    do_clr();

    // R10 set wins over a coincident clear
    do_begin('hFC00, 1, 1'b1);
    chk(err_flag == 1'b1, "R10 set beats clear", int'(err_flag), 1);
    do_stop();
    do_clr();
    chk(err_flag == 1'b0, "R10 cleared", int'(err_flag), 0);
    do_clr();
    chk(err_flag == 1'b0, "R10 stays clear", int'(err_flag), 0);

    // random phase
    for (int p = 0; p < NPG; p++)
      if (!erased[p] && ($urandom_range(0, 3) != 0)) do_erase(p);
    for (int t = 0; t < 300; t++) begin
      case ($urandom_range(0, 3))
        0: a = int'($urandom_range(0, 'hFFFF));
        1: a = 'hFBF8 + int'($urandom_range(0, 15));
        2: a = (int'($urandom_range(0, NPG - 1)) << 8) + 250 + int'($urandom_range(0, 5));
        default: a = int'($urandom_range(0, TOP));
      endcase
      if (a > 'hFFFF) a = 'hFFFF;
      n  = int'($urandom_range(1, 6));
      ns = n;
      if ($urandom_range(0, 4) == 0) ns = n + 1;
      else if ($urandom_range(0, 4) == 0) ns = n - 1;
      run_txn(a, n, ns, "R6");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule